// File: doc/BRIEF.md
# Segmented Current-DAC Code Decoder

This block turns an 8-bit bias setting into the switch enables of a segmented current-steering DAC. The code is split in two. The lower two bits drive a pair of binary-weighted cells directly, worth 1 and 2 units. The upper six bits form a level N that switches on exactly N cells out of an array of 64 equal cells. Each of those cells is worth 4 units. Code 255 therefore enables 255 units in total, and every step of the code adds exactly one unit.

The code arrives serially into a holding register, least significant bit first, while the shift enable is high. The cell enables do not follow the holding register. They change only after a load strobe that arrives while no shift is in progress, so a partly shifted word never reaches the cells. A small controller sequences the update. It has three states:
- ST_IDLE: no activity.
- ST_SHIFT: shifting is under way.
- ST_APPLY: the one-cycle state in which the output register captures the held code.

The controller takes the same transitions from every state:
- shift enable high: go to ST_SHIFT. This takes priority over the load strobe.
- load strobe high with shift enable low: go to ST_APPLY.
- neither input high: go to ST_IDLE.

All enables leave registers, so each cell switches on a single clock edge.

Top module: `dac_seg_decoder`

## Requirements
- R1: On each rising clock edge with `cfg_shift` high, the holding register shifts one place toward bit 0 and `cfg_sdi` enters bit 7. A code is therefore sent least significant bit first. `cfg_sdo` always shows holding-register bit 0, and the register is unchanged when `cfg_shift` is low.
- R2: `bin_en[0]` equals bit 0 of the applied code (weight 1), and `bin_en[1]` equals bit 1 (weight 2).
- R3: `unit_en[k]` is 1 exactly when the applied code's bits 7..2, read as an unsigned level, exceed k, for k from 0 to 63.
- R4: `unit_en[63]` is always 0 and serves as a spare cell.
- R5: The enabled weight is 4 × (number of `unit_en` bits set) + `bin_en` read as a number. This weight equals the applied code, and code 255 gives 255.
- R6: Suppose `cfg_load` is high and `cfg_shift` is low at rising edge k. The outputs then take the value the holding register had at that point, and they change on edge k+1. At every other edge the outputs keep their value.
- R7: While `rst_n` is low, all enables and the holding register are 0 and the controller is in ST_IDLE.
- R8: A `cfg_load` that is high at the same edge as `cfg_shift` is ignored, and the outputs keep their previous value.
- R9: When the applied code steps from c to c+1, the enabled weight rises by exactly one and no unit cell that was on turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shift enable for the holding register |
| cfg_sdi | input | 1 | Serial code input, least significant bit first |
| cfg_load | input | 1 | Load strobe that applies the held code |
| cfg_sdo | output | 1 | Holding-register bit 0 |
| bin_en | output | 2 | Binary cell enables (weights 1, 2) |
| unit_en | output | 64 | Thermometer enables of the unit cells |

## Verification
The hardest case to reach from the ports is a load strobe that coincides with a shift. That case must leave the cells untouched even though the holding register moves on the same edge. The bench sets up this case by shifting in a word, then raising the shift enable and the strobe together for one extra bit. It then checks that the old code stays applied, and that the next clean strobe applies the shifted word. The monotonic property is covered by a full sweep of all 256 codes, comparing each applied state with the one before it.

// File: rtl/dacdec_pkg.sv
package dacdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_APPLY = 2'd2
    } dac_state_e;
endpackage

// File: rtl/dacdec_shadow.sv
module dacdec_shadow #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              sdi_i,
    output logic [CODE_W-1:0] code_o,
    output logic              sdo_o
);
    logic [CODE_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (shift_i) begin
            hold_q <= {sdi_i, hold_q[CODE_W-1:1]};
        end
    end

    assign code_o = hold_q;
    assign sdo_o  = hold_q[0];

    assert_shift_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (sdo_o == $past(code_o[1])) && (code_o[CODE_W-1] == $past(sdi_i)));

    assert_shadow_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(code_o));
endmodule

// File: rtl/dacdec_ctrl.sv
module dacdec_ctrl
    import dacdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_i,
    input  logic load_i,
    output logic commit_o
);
    dac_state_e state_q;
    dac_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (shift_i)     state_d = ST_SHIFT;
                else if (load_i) state_d = ST_APPLY;
                else             state_d = ST_IDLE;
            end
            ST_SHIFT: begin
                if (shift_i)     state_d = ST_SHIFT;
                else if (load_i) state_d = ST_APPLY;
                else             state_d = ST_IDLE;
            end
            ST_APPLY: begin
                if (shift_i)     state_d = ST_SHIFT;
                else if (load_i) state_d = ST_APPLY;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        commit_o = (state_q == ST_APPLY);
    end

    assert_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && load_i) |=> !commit_o);

    assert_commit_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !shift_i) |=> commit_o);

    assert_reset_idle_R7: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE) || rst_n);
endmodule

// File: rtl/dacdec_therm.sv
module dacdec_therm #(
    parameter int UNARY_W = 6,
    parameter int CELLS   = 64
) (
    input  logic [UNARY_W-1:0] level_i,
    output logic [CELLS-1:0]   therm_o
);
    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        assign therm_o[g] = (32'(level_i) > g);
    end

    always_comb begin
        if (!$isunknown(level_i)) begin
            assert_therm_count_R3: assert ($countones(therm_o) == int'(level_i));
        end
    end
endmodule

// File: rtl/dacdec_outreg.sv
module dacdec_outreg #(
    parameter int CODE_W = 8,
    parameter int BIN_W  = 2,
    parameter int CELLS  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CELLS-1:0]  therm_i,
    output logic [BIN_W-1:0]  bin_o,
    output logic [CELLS-1:0]  unit_o
);
    localparam int UNIT_WT = 1 << BIN_W;

    logic [BIN_W-1:0] bin_q;
    logic [CELLS-1:0] unit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            unit_q <= '0;
        end else if (commit_i) begin
            bin_q  <= code_i[BIN_W-1:0];
            unit_q <= therm_i;
        end
    end

    assign bin_o  = bin_q;
    assign unit_o = unit_q;

    assert_weight_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (($countones(unit_q) * UNIT_WT) + int'(bin_q)) == int'($past(code_i)));

    assert_spare_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unit_q[CELLS-1] == 1'b0);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(unit_q) && $stable(bin_q));

    assert_reset_zero_R7: assert property (@(posedge clk)
        !rst_n |=> (unit_q == '0) && (bin_q == '0));
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder #(
    parameter int CODE_W = 8,
    parameter int BIN_W  = 2,
    localparam int UNARY_W = CODE_W - BIN_W,
    localparam int CELLS   = 1 << UNARY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_sdi,
    input  logic             cfg_load,
    output logic             cfg_sdo,
    output logic [BIN_W-1:0] bin_en,
    output logic [CELLS-1:0] unit_en
);
    logic [CODE_W-1:0] held_code;
    logic [CELLS-1:0]  therm;
    logic              commit;

    dacdec_shadow #(.CODE_W(CODE_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (cfg_shift),
        .sdi_i   (cfg_sdi),
        .code_o  (held_code),
        .sdo_o   (cfg_sdo)
    );

    dacdec_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_i  (cfg_shift),
        .load_i   (cfg_load),
        .commit_o (commit)
    );

    dacdec_therm #(.UNARY_W(UNARY_W), .CELLS(CELLS)) u_therm (
        .level_i (held_code[CODE_W-1:BIN_W]),
        .therm_o (therm)
    );

    dacdec_outreg #(.CODE_W(CODE_W), .BIN_W(BIN_W), .CELLS(CELLS)) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .code_i   (held_code),
        .therm_i  (therm),
        .bin_o    (bin_en),
        .unit_o   (unit_en)
    );
endmodule

// File: tb/dac_seg_decoder_tb_top.sv
module dac_seg_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_shift = 1'b0;
    logic        cfg_sdi = 1'b0;
    logic        cfg_load = 1'b0;
    logic        cfg_sdo;
    logic [1:0]  bin_en;
    logic [63:0] unit_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_seg_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
        .cfg_load(cfg_load), .cfg_sdo(cfg_sdo), .bin_en(bin_en), .unit_en(unit_en)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_hold = 0;
    bit          m_commit = 1'b0;
    int          m_code = 0;
    logic [63:0] m_unit;
    logic [1:0]  m_bin;

    always_comb begin
        m_unit = '0;
        for (int k = 0; k < 64; k++) m_unit[k] = ((m_code / 4) > k);
        m_bin = 2'(m_code % 4);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hold = 0; m_commit = 1'b0; m_code = 0;
        end else begin
            if (m_commit) m_code = m_hold;
            m_commit = cfg_load && !cfg_shift;
            if (cfg_shift) m_hold = (m_hold >> 1) | (int'(cfg_sdi) << 7);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(unit_en == m_unit, "R6 units vs model", unit_en, m_unit);
            chk(bin_en == m_bin, "R6 binary vs model", 64'(bin_en), 64'(m_bin));
            chk(cfg_sdo == m_hold[0], "R1 sdo vs model", 64'(cfg_sdo), 64'(m_hold[0]));
        end
    end

    function automatic int weight_of(input logic [63:0] u, input logic [1:0] b);
        return $countones(u) * 4 + int'(b);
    endfunction

    task automatic shift_word(input logic [7:0] c, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            cfg_shift = 1'b1; cfg_sdi = c[i];
            @(negedge clk);
            got[i] = cfg_sdo;
        end
        @(posedge clk); #1;
        cfg_shift = 1'b0; cfg_sdi = 1'b0;
    endtask

    task automatic strobe();
        @(posedge clk); #1; cfg_load = 1'b1;
        @(posedge clk); #1; cfg_load = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(input logic [7:0] c);
        logic [7:0] dummy;
        shift_word(c, dummy);
        strobe();
    endtask

    task automatic check_code(input int c);
        logic [63:0] e;
        e = '0;
        for (int k = 0; k < 64; k++) e[k] = ((c / 4) > k);
        chk(bin_en == 2'(c % 4), "R2 binary cells", 64'(bin_en), 64'(c % 4));
        chk(unit_en == e, "R3 thermometer", unit_en, e);
        chk(unit_en[63] == 1'b0, "R4 spare cell", 64'(unit_en[63]), 64'd0);
        chk(weight_of(unit_en, bin_en) == c, "R5 total weight", 64'(weight_of(unit_en, bin_en)), 64'(c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic [63:0] prev_u;
        int prev_w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(unit_en == '0 && bin_en == 2'b00, "R7 reset enables", unit_en, 64'd0);
        chk(cfg_sdo == 1'b0, "R7 reset holding", 64'(cfg_sdo), 64'd0);
        #1 rst_n = 1'b1;

        apply(8'd0);   check_code(0);
        apply(8'd1);   check_code(1);
        apply(8'd2);   check_code(2);
        apply(8'd3);   check_code(3);
        apply(8'd4);   check_code(4);
        apply(8'hAA);  check_code(8'hAA);
        apply(8'h55);  check_code(8'h55);
        apply(8'd252); check_code(252);
        apply(8'd255); check_code(255);
        chk(weight_of(unit_en, bin_en) == 255, "R5 full scale", 64'(weight_of(unit_en, bin_en)), 64'd255);

        // R1: serial order, read back through sdo
        shift_word(8'hC6, got);
        shift_word(8'h00, got);
        chk(got == 8'hC6, "R1 serial lsb first", 64'(got), 64'hC6);
        check_code(255);

        // R6: exact update edge
        shift_word(8'd128, got);
        @(posedge clk); #1; cfg_load = 1'b1;
        @(posedge clk); #1; cfg_load = 1'b0;
        @(negedge clk);
        check_code(255);
        @(posedge clk); @(negedge clk);
        check_code(128);

        // R8: load during shift ignored
        apply(8'd9); check_code(9);
        shift_word(8'd200, got);
        @(posedge clk); #1; cfg_shift = 1'b1; cfg_sdi = 1'b0; cfg_load = 1'b1;
        @(posedge clk); #1; cfg_shift = 1'b0; cfg_load = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(unit_en == 64'h3 && bin_en == 2'd1, "R8 load ignored", unit_en, 64'h3);
        strobe();
        check_code(100);

        // R9: full monotonic sweep
        apply(8'd0);
        prev_u = unit_en; prev_w = weight_of(unit_en, bin_en);
        for (int c = 1; c < 256; c++) begin
            apply(8'(c));
            chk(weight_of(unit_en, bin_en) == prev_w + 1, "R9 weight step",
                64'(weight_of(unit_en, bin_en)), 64'(prev_w + 1));
            chk((prev_u & ~unit_en) == '0, "R9 no cell off", prev_u & ~unit_en, 64'd0);
            prev_u = unit_en; prev_w = weight_of(unit_en, bin_en);
        end

        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule